// File: doc/BRIEF.md
# Endpoint-0 Standard Request Autodecoder

This block sits next to endpoint 0 of a full-speed USB device core. It takes in the eight setup bytes and per-transaction event strobes from the packet layer. The packet layer has already checked CRC, PID and bit stuffing, and it reports a bad token or a bad data packet on an error strobe. For every accepted setup packet the block sorts the request into one of three groups. Requests it handles itself change the device address or the remote-wakeup flag. Requests passed to software raise a one-cycle hand-off pulse. Malformed or undefined requests are refused. It also records whether the request is a control read or a control write.

For every endpoint-0 transaction the block returns a handshake decision: ACK, NAK or STALL, or no handshake at all when a setup transaction arrives corrupted. Requests the block handles itself never disturb the processor. A feature change takes effect as soon as the setup packet is accepted. A new address is held back until the status-stage transaction of the same request has finished, and it is applied whether or not the host acknowledged that transaction.

Top module: `ep0_std_autodec`

## Requirements
- R1: After reset, dev_addr is 0, addressed and rwake_en are 0, and hs_vld, cpu_req and req_rd are 0.
- R2: A setup transaction whose token and data packet both arrive clean is accepted. In the cycle after the packet strobe, hs_vld is 1 with hs_code ACK (encoding: 0 = ACK, 1 = NAK, 2 = STALL), and req_rd takes bit 7 of byte 0.
- R3: If the setup token arrives with tok_err, or the setup packet arrives with pkt_err, no handshake is produced. The request is not accepted, so the address, the flags and the active request stay as they were.
- R4: SET_ADDRESS is byte0 = 0x00, byte1 = 0x05, with the address in the low ADDR_W bits of the wValue field (bytes 2–3, little endian), upper wValue bits zero, and wIndex (bytes 4–5) and wLength (bytes 6–7) zero. The new address is stored as pending. dev_addr changes only in the cycle after txn_done ends that request's status stage. The status stage is the first stage token whose direction (stage_in) differs from req_rd. If a new setup is accepted first, the pending address is dropped.
- R5: When the pending address is committed, addressed becomes 1 if that address is nonzero. A zero address leaves addressed unchanged.
- R6: SET_FEATURE (byte1 = 0x03) and CLEAR_FEATURE (byte1 = 0x01) with byte0 = 0x00, wValue = FEAT_RWAKE (1), and wIndex and wLength zero, set or clear rwake_en in the cycle after the setup packet is accepted, without waiting for any later stage.
- R7: A set or clear feature request with byte0 = 0x01 (interface recipient) is STALLed on every later stage token, and rwake_en is left unchanged.
- R8: Any other request is refused: data/status stage tokens get STALL and cpu_req stays 0. This covers reserved type 3 (byte0 bits 6:5 = 3), standard codes outside the handled and hand-off sets, and malformed SET_ADDRESS or device-feature requests.
- R9: Some requests are handed to software. These are class or vendor types (byte0 bits 6:5 = 1 or 2), standard codes 0 and 6–12, and feature requests to an endpoint (byte0 = 0x02). For these, cpu_req pulses for one cycle after acceptance. Their stage tokens get STALL if sw_stall is set, otherwise ACK if sw_fifo_en is set, otherwise NAK.
- R10: Stage tokens of a request the block handles itself (R4, R6) get ACK whatever sw_stall and sw_fifo_en say, and cpu_req never pulses for them.
- R11: A stage token with no active request gets STALL. A request stops being active at the txn_done that ends its status stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_tok | input | 1 | Setup token seen on endpoint 0 |
| tok_err | input | 1 | Token with setup_tok was corrupted |
| setup_pkt | input | 1 | Setup data packet received |
| pkt_err | input | 1 | Data packet with setup_pkt was corrupted |
| setup_bytes | input | 64 | Setup bytes, byte 0 in bits 7:0 |
| stage_tok | input | 1 | Data or status stage token on endpoint 0 |
| stage_in | input | 1 | Direction of stage_tok: 1 = IN, 0 = OUT |
| txn_done | input | 1 | Stage transaction finished, whatever the handshake |
| sw_stall | input | 1 | Software stall command |
| sw_fifo_en | input | 1 | Software FIFO ready |
| hs_vld | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| cpu_req | output | 1 | One-cycle hand-off pulse to software |
| req_rd | output | 1 | Active request is a control read |
| dev_addr | output | ADDR_W | Live device address |
| addressed | output | 1 | Device is in the addressed state |
| rwake_en | output | 1 | Remote wakeup enabled |

## Verification
The bench builds the block with its defaults: a 7-bit address, remote-wakeup selector 1, and the standard hand-off mask covering codes 0 and 6–12. With a 7-bit address, the largest legal address 0x7F and the first out-of-range wValue 0x80 can both be reached, so the malformed SET_ADDRESS path is exercised. With the default mask, requests on either side of the hand-off set can be reached as well: GET_DESCRIPTOR goes to software, while code 0x02 and a test-mode feature selector are refused.

// File: rtl/ep0dec_pkg.sv
package ep0dec_pkg;

   typedef enum logic [1:0] {
      HS_ACK   = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2
   } hs_e;

   typedef enum logic [2:0] {
      RK_IDLE  = 3'd0,
      RK_ADDR  = 3'd1,
      RK_FEAT  = 3'd2,
      RK_CPU   = 3'd3,
      RK_STALL = 3'd4
   } rkind_e;

   localparam logic [7:0] BREQ_CLR_FEAT = 8'h01;
   localparam logic [7:0] BREQ_SET_FEAT = 8'h03;
   localparam logic [7:0] BREQ_SET_ADDR = 8'h05;

endpackage

// File: rtl/ep0_req_classify.sv
module ep0_req_classify
   import ep0dec_pkg::*;
#(
   parameter int          ADDR_W       = 7,
   parameter int          FEAT_RWAKE   = 1,
   parameter logic [15:0] CPU_STD_MASK = 16'h1FC1
) (
   input  logic [63:0]       setup_bytes,
   output rkind_e            kind,
   output logic              is_rd,
   output logic              feat_on,
   output logic [ADDR_W-1:0] new_addr
);

   localparam int MASK_N = 16;

   logic [7:0]  rtype;
   logic [7:0]  breq;
   logic [15:0] wval;
   logic [15:0] widx;
   logic [15:0] wlen;

   assign rtype = setup_bytes[7:0];
   assign breq  = setup_bytes[15:8];
   assign wval  = setup_bytes[31:16];
   assign widx  = setup_bytes[47:32];
   assign wlen  = setup_bytes[63:48];

   logic [MASK_N-1:0] hitv;
   for (genvar i = 0; i < MASK_N; i++) begin : g_hit
      assign hitv[i] = CPU_STD_MASK[i] && (breq == 8'(i));
   end
   logic cpu_std;
   assign cpu_std = |hitv;

   logic no_tail;
   logic is_feat;
   logic addr_ok;
   logic feat_ok;
   assign no_tail = (widx == 16'h0) && (wlen == 16'h0);
   assign is_feat = (breq == BREQ_SET_FEAT) || (breq == BREQ_CLR_FEAT);
   assign addr_ok = (rtype == 8'h00) && (breq == BREQ_SET_ADDR) &&
                    (wval[15:ADDR_W] == '0) && no_tail;
   assign feat_ok = (rtype == 8'h00) && is_feat &&
                    (wval == 16'(FEAT_RWAKE)) && no_tail;

   always_comb begin
      unique case (rtype[6:5])
         2'b00: begin
            if (addr_ok)                         kind = RK_ADDR;
            else if (feat_ok)                    kind = RK_FEAT;
            else if (is_feat && rtype == 8'h02)  kind = RK_CPU;
            else if (cpu_std)                    kind = RK_CPU;
            else                                 kind = RK_STALL;
         end
         2'b11:   kind = RK_STALL;
         default: kind = RK_CPU;
      endcase
   end

   assign is_rd    = rtype[7];
   assign feat_on  = (breq == BREQ_SET_FEAT);
   assign new_addr = wval[ADDR_W-1:0];

endmodule

// File: rtl/ep0_stage_ctl.sv
module ep0_stage_ctl
   import ep0dec_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   setup_tok,
   input  logic   tok_err,
   input  logic   setup_pkt,
   input  logic   pkt_err,
   input  logic   stage_tok,
   input  logic   stage_in,
   input  logic   txn_done,
   input  logic   sw_stall,
   input  logic   sw_fifo_en,
   input  rkind_e cls_kind,
   input  logic   cls_rd,
   output logic   hs_vld,
   output hs_e    hs_code,
   output logic   cpu_req,
   output logic   req_rd,
   output logic   acc_stb,
   output logic   commit_stb
);

   logic   armed;
   logic   in_stat;
   rkind_e kind;
   hs_e    stage_hs;

   assign acc_stb    = setup_pkt && armed && !pkt_err;
   assign commit_stb = txn_done && in_stat && (kind == RK_ADDR);

   always_comb begin
      unique case (kind)
         RK_ADDR, RK_FEAT: stage_hs = HS_ACK;
         RK_CPU:           stage_hs = sw_stall   ? HS_STALL :
                                      sw_fifo_en ? HS_ACK : HS_NAK;
         default:          stage_hs = HS_STALL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         in_stat <= 1'b0;
         kind    <= RK_IDLE;
         req_rd  <= 1'b0;
         hs_vld  <= 1'b0;
         hs_code <= HS_ACK;
         cpu_req <= 1'b0;
      end else begin
         hs_vld  <= 1'b0;
         cpu_req <= 1'b0;
         if (setup_tok) armed <= !tok_err;
         if (setup_pkt) begin
            armed <= 1'b0;
            if (acc_stb) begin
               kind    <= cls_kind;
               req_rd  <= cls_rd;
               in_stat <= 1'b0;
               hs_vld  <= 1'b1;
               hs_code <= HS_ACK;
               cpu_req <= (cls_kind == RK_CPU);
            end
         end
         if (stage_tok) begin
            hs_vld  <= 1'b1;
            hs_code <= stage_hs;
            if (kind != RK_IDLE && stage_in != req_rd) in_stat <= 1'b1;
         end
         if (txn_done && in_stat) begin
            kind    <= RK_IDLE;
            in_stat <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ep0_dev_regs.sv
module ep0_dev_regs
   import ep0dec_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_stb,
   input  rkind_e            cls_kind,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic              feat_on,
   input  logic              commit_stb,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              addressed,
   output logic              rwake_en
);

   logic [ADDR_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow    <= '0;
         dev_addr  <= '0;
         addressed <= 1'b0;
         rwake_en  <= 1'b0;
      end else begin
         if (acc_stb && cls_kind == RK_ADDR) shadow   <= new_addr;
         if (acc_stb && cls_kind == RK_FEAT) rwake_en <= feat_on;
         if (commit_stb) begin
            dev_addr <= shadow;
            if (shadow != '0) addressed <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ep0_std_autodec.sv
module ep0_std_autodec
   import ep0dec_pkg::*;
#(
   parameter int          ADDR_W       = 7,
   parameter int          FEAT_RWAKE   = 1,
   parameter logic [15:0] CPU_STD_MASK = 16'h1FC1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              setup_tok,
   input  logic              tok_err,
   input  logic              setup_pkt,
   input  logic              pkt_err,
   input  logic [63:0]       setup_bytes,
   input  logic              stage_tok,
   input  logic              stage_in,
   input  logic              txn_done,
   input  logic              sw_stall,
   input  logic              sw_fifo_en,
   output logic              hs_vld,
   output logic [1:0]        hs_code,
   output logic              cpu_req,
   output logic              req_rd,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              addressed,
   output logic              rwake_en
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 7)
         else $fatal(1, "ADDR_W must be 1..7");
      assert (FEAT_RWAKE >= 0 && FEAT_RWAKE < 65536)
         else $fatal(1, "FEAT_RWAKE must fit 16 bits");
      assert (!CPU_STD_MASK[1] && !CPU_STD_MASK[3] && !CPU_STD_MASK[5])
         else $fatal(1, "CPU_STD_MASK overlaps autodecoded codes");
   end

   rkind_e            cls_kind;
   logic              cls_rd;
   logic              feat_on;
   logic [ADDR_W-1:0] new_addr;
   logic              acc_stb;
   logic              commit_stb;
   hs_e               hs_q;

   ep0_req_classify #(
      .ADDR_W      (ADDR_W),
      .FEAT_RWAKE  (FEAT_RWAKE),
      .CPU_STD_MASK(CPU_STD_MASK)
   ) u_cls (
      .setup_bytes(setup_bytes),
      .kind       (cls_kind),
      .is_rd      (cls_rd),
      .feat_on    (feat_on),
      .new_addr   (new_addr)
   );

   ep0_stage_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .setup_tok (setup_tok),
      .tok_err   (tok_err),
      .setup_pkt (setup_pkt),
      .pkt_err   (pkt_err),
      .stage_tok (stage_tok),
      .stage_in  (stage_in),
      .txn_done  (txn_done),
      .sw_stall  (sw_stall),
      .sw_fifo_en(sw_fifo_en),
      .cls_kind  (cls_kind),
      .cls_rd    (cls_rd),
      .hs_vld    (hs_vld),
      .hs_code   (hs_q),
      .cpu_req   (cpu_req),
      .req_rd    (req_rd),
      .acc_stb   (acc_stb),
      .commit_stb(commit_stb)
   );

   assign hs_code = hs_q;

   ep0_dev_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_stb   (acc_stb),
      .cls_kind  (cls_kind),
      .new_addr  (new_addr),
      .feat_on   (feat_on),
      .commit_stb(commit_stb),
      .dev_addr  (dev_addr),
      .addressed (addressed),
      .rwake_en  (rwake_en)
   );

endmodule

// File: rtl/ep0_std_autodec_chk.sv
module ep0_std_autodec_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              setup_pkt,
   input logic              pkt_err,
   input logic              stage_tok,
   input logic              txn_done,
   input logic              hs_vld,
   input logic [1:0]        hs_code,
   input logic              cpu_req,
   input logic [ADDR_W-1:0] dev_addr,
   input logic              addressed,
   input logic              rwake_en
);

   // R2: a handshake always answers a setup packet or a stage token
   a_r2_hs_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      hs_vld |-> $past(setup_pkt || stage_tok));

   // R3: a corrupted setup packet on its own yields no handshake
   a_r3_corrupt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_pkt && pkt_err && !stage_tok) |=> !hs_vld);

   // R4: the live address moves only after a finished stage transaction
   a_r4_addr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr) |-> $past(txn_done));

   // R5: the addressed state is never left without reset
   a_r5_addressed_holds: assert property (@(posedge clk) disable iff (!rst_n)
      addressed |=> addressed);

   // R6: remote wakeup changes only right after a clean setup packet
   a_r6_rwake_on_setup: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rwake_en) |-> $past(setup_pkt && !pkt_err));

   // R9: the hand-off pulse follows a clean setup packet
   a_r9_cpu_req_on_setup: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> $past(setup_pkt && !pkt_err));

   // R11: only defined handshake codes appear
   a_r11_hs_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      hs_vld |-> (hs_code != 2'd3));

endmodule

bind ep0_std_autodec ep0_std_autodec_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .setup_pkt(setup_pkt),
   .pkt_err  (pkt_err),
   .stage_tok(stage_tok),
   .txn_done (txn_done),
   .hs_vld   (hs_vld),
   .hs_code  (hs_code),
   .cpu_req  (cpu_req),
   .dev_addr (dev_addr),
   .addressed(addressed),
   .rwake_en (rwake_en)
);

// File: tb/sim_ep0_std_autodec.sv
module sim_ep0_std_autodec;

   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          setup_tok = 1'b0, tok_err = 1'b0;
   logic          setup_pkt = 1'b0, pkt_err = 1'b0;
   logic [63:0]   setup_bytes = '0;
   logic          stage_tok = 1'b0, stage_in = 1'b0;
   logic          txn_done = 1'b0;
   logic          sw_stall = 1'b0, sw_fifo_en = 1'b0;
   logic          hs_vld;
   logic [1:0]    hs_code;
   logic          cpu_req;
   logic          req_rd;
   logic [AW-1:0] dev_addr;
   logic          addressed;
   logic          rwake_en;

   always #5 clk = ~clk;

   ep0_std_autodec u0 (
      .clk(clk), .rst_n(rst_n),
      .setup_tok(setup_tok), .tok_err(tok_err),
      .setup_pkt(setup_pkt), .pkt_err(pkt_err), .setup_bytes(setup_bytes),
      .stage_tok(stage_tok), .stage_in(stage_in), .txn_done(txn_done),
      .sw_stall(sw_stall), .sw_fifo_en(sw_fifo_en),
      .hs_vld(hs_vld), .hs_code(hs_code), .cpu_req(cpu_req), .req_rd(req_rd),
      .dev_addr(dev_addr), .addressed(addressed), .rwake_en(rwake_en)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model state; kinds: 0 idle 1 address 2 feature 3 software 4 refuse
   int       m_kind = 0;
   bit       m_armed = 0, m_stat = 0, m_rd = 0;
   int       m_shadow = 0, m_addr = 0;
   bit       m_addressed = 0, m_rwake = 0;
   bit       e_vld = 0, e_cpu = 0;
   int       e_code = 0;

   function automatic int sort_req(logic [63:0] s);
      int rt = int'(s[7:0]);
      int rq = int'(s[15:8]);
      int wv = int'(s[31:16]);
      int wi = int'(s[47:32]);
      int wl = int'(s[63:48]);
      int ty = (rt >> 5) & 3;
      if (ty == 3) return 4;
      if (ty != 0) return 3;
      if (rq == 5 && rt == 0 && wv < 128 && wi == 0 && wl == 0) return 1;
      if ((rq == 1 || rq == 3) && rt == 0 && wv == 1 && wi == 0 && wl == 0) return 2;
      if ((rq == 1 || rq == 3) && rt == 2) return 3;
      if (rq == 0 || (rq >= 6 && rq <= 12)) return 3;
      return 4;
   endfunction

   function automatic logic [63:0] mk(int rt, int rq, int wv, int wi, int wl);
      return {16'(wl), 16'(wi), 16'(wv), 8'(rq), 8'(rt)};
   endfunction

   task automatic model_step();
      e_vld = 0; e_cpu = 0;
      if (!rst_n) begin
         m_kind = 0; m_armed = 0; m_stat = 0; m_rd = 0;
         m_shadow = 0; m_addr = 0; m_addressed = 0; m_rwake = 0;
         return;
      end
      if (setup_tok) m_armed = !tok_err;
      if (setup_pkt) begin
         if (m_armed && !pkt_err) begin
            m_kind = sort_req(setup_bytes);
            m_rd = setup_bytes[7];
            m_stat = 0;
            e_vld = 1; e_code = 0;
            e_cpu = (m_kind == 3);
            if (m_kind == 2) m_rwake = (setup_bytes[15:8] == 8'h03);
            if (m_kind == 1) m_shadow = int'(setup_bytes[16 +: AW]);
         end
         m_armed = 0;
      end
      if (stage_tok) begin
         e_vld = 1;
         if (m_kind == 1 || m_kind == 2) e_code = 0;
         else if (m_kind == 3) e_code = sw_stall ? 2 : (sw_fifo_en ? 0 : 1);
         else e_code = 2;
         if (m_kind != 0 && stage_in != m_rd) m_stat = 1;
      end
      if (txn_done && m_stat) begin
         if (m_kind == 1) begin
            m_addr = m_shadow;
            if (m_shadow != 0) m_addressed = 1;
         end
         m_kind = 0; m_stat = 0;
      end
   endtask

   task automatic compare(string tag);
      bit ok;
      ok = (hs_vld == e_vld) && (!e_vld || int'(hs_code) == e_code) &&
           (cpu_req == e_cpu) && (int'(dev_addr) == m_addr) &&
           (addressed == m_addressed) && (rwake_en == m_rwake) && (req_rd == m_rd);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual vld=%0d code=%0d cpu=%0d addr=%0d adr=%0d rw=%0d rd=%0d expected vld=%0d code=%0d cpu=%0d addr=%0d adr=%0d rw=%0d rd=%0d",
                  tag, hs_vld, hs_code, cpu_req, dev_addr, addressed, rwake_en, req_rd,
                  e_vld, e_code, e_cpu, m_addr, m_addressed, m_rwake, m_rd);
      end
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
      setup_tok = 0; tok_err = 0; setup_pkt = 0; pkt_err = 0;
      stage_tok = 0; txn_done = 0;
   endtask

   task automatic setup(logic [63:0] b, bit terr, bit perr, string tag);
      setup_tok = 1; tok_err = terr;
      cyc(tag);
      setup_pkt = 1; pkt_err = perr; setup_bytes = b;
      cyc(tag);
   endtask

   task automatic stage(bit dir_in, string tag);
      stage_tok = 1; stage_in = dir_in;
      cyc(tag);
   endtask

   task automatic done(string tag);
      txn_done = 1;
      cyc(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) cyc("R1 reset");
      rst_n = 1;
      cyc("R1 idle");

      // R6 set remote wakeup, no status stage follows; R10 no hand-off
      setup(mk(8'h00, 8'h03, 1, 0, 0), 0, 0, "R6 set feature");
      cyc("R10 quiet");
      // R10 clear with software stall active: stage still ACKed
      sw_stall = 1;
      setup(mk(8'h00, 8'h01, 1, 0, 0), 0, 0, "R6 clear feature");
      stage(1, "R10 status ack despite stall");
      done("R11 end feature");
      sw_stall = 0;

      // R4 address held until status done; R5 addressed
      sw_fifo_en = 0; sw_stall = 1;
      setup(mk(8'h00, 8'h05, 8'h2A, 0, 0), 0, 0, "R4 set address");
      stage(1, "R10 address status ack");
      cyc("R4 still pending");
      done("R5 committed nonzero");
      sw_stall = 0;
      stage(1, "R11 idle stage stall");

      // R5 zero address keeps addressed
      setup(mk(8'h00, 8'h05, 0, 0, 0), 0, 0, "R5 zero address");
      stage(1, "R5 status");
      done("R5 zero commit");

      // R4 pending address dropped by a new setup (GET_STATUS read)
      setup(mk(8'h00, 8'h05, 8'h11, 0, 0), 0, 0, "R4 pending");
      setup(mk(8'h80, 8'h00, 0, 0, 2), 0, 0, "R4 overtaken");
      sw_fifo_en = 1;
      stage(1, "R9 data in");
      stage(0, "R9 status out");
      done("R4 no commit");
      sw_fifo_en = 0;

      // R4 maximum address
      setup(mk(8'h00, 8'h05, 8'h7F, 0, 0), 0, 0, "R4 max address");
      stage(1, "R4 status");
      done("R4 max commit");

      // R3 corrupted token, corrupted packet
      setup(mk(8'h00, 8'h03, 1, 0, 0), 1, 0, "R3 bad token");
      setup(mk(8'h00, 8'h03, 1, 0, 0), 0, 1, "R3 bad packet");
      stage(1, "R3 still idle");

      // R7 interface feature
      setup(mk(8'h01, 8'h03, 1, 0, 0), 0, 0, "R7 interface feature");
      stage(1, "R7 stall");
      done("R7 end");

      // R8 refused requests
      setup(mk(8'h00, 8'h02, 0, 0, 0), 0, 0, "R8 undefined code");
      stage(1, "R8 stall");
      setup(mk(8'h60, 8'h06, 0, 0, 0), 0, 0, "R8 reserved type");
      stage(0, "R8 stall");
      setup(mk(8'h00, 8'h05, 8'h80, 0, 0), 0, 0, "R8 address range");
      stage(1, "R8 stall");
      done("R8 no commit");
      setup(mk(8'h00, 8'h05, 3, 0, 1), 0, 0, "R8 address length");
      stage(1, "R8 stall");
      setup(mk(8'h00, 8'h03, 2, 0, 0), 0, 0, "R8 test mode selector");
      stage(1, "R8 stall");
      done("R8 end");

      // R9 software requests and their stage handshakes
      setup(mk(8'h80, 8'h06, 16'h0100, 0, 18), 0, 0, "R9 get descriptor");
      stage(1, "R9 nak");
      sw_fifo_en = 1;
      stage(1, "R9 ack");
      sw_stall = 1;
      stage(1, "R9 stall");
      sw_stall = 0; sw_fifo_en = 0;
      setup(mk(8'h21, 8'h09, 0, 0, 0), 0, 0, "R9 class write");
      setup(mk(8'h02, 8'h03, 0, 1, 0), 0, 0, "R9 endpoint feature");
      sw_fifo_en = 1;
      stage(1, "R9 status");
      done("R11 end");
      sw_fifo_en = 0;
      stage(0, "R11 idle stall");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule